// File: doc/BRIEF.md
# 32-bit ALU with condition flags

This block performs the two-operand integer operations of a simple processor. Each operation works on a register operand and a register-or-memory ("r/m") operand. The operations are add, subtract, AND, OR, XOR, compare and bitwise NOT.

The execution stage presents the opcode byte, the 3-bit subfield from the operand-format byte, and both operands. It qualifies them with a valid strobe.

- **Outputs in the same cycle:** the block returns the result, a write enable, and a select that says whether the result goes back to the r/m location or to the register named by the subfield.
- **Outputs after the clock edge:** the sign, zero, carry and overflow flags are kept in registers, so they live from one instruction to the next.
- **Unknown encodings:** an encoding the block does not know is reported on a one-cycle illegal-operation pulse.

Top module: `alu_flags_unit`

## Requirements
- R1: Opcodes 0x01/0x03 add, 0x29/0x2B subtract, 0x21/0x23 AND, 0x09/0x0B OR, 0x31/0x33 XOR, and 0x39/0x3B compare. `result_o` carries the 32-bit wrapped outcome while `valid_i` is high.
- R2: Opcode bit 1 picks the destination.
  - Bit 1 clear: the result goes to r/m, and `wr_to_rm_o`=1.
  - Bit 1 set: the result goes to the register, and `wr_to_rm_o`=0.
  - `wr_en_o` is high only while `valid_i` is high and the operation writes back.
- R3: Subtract order follows the direction.
  - Opcode 0x29 computes r/m minus register.
  - Opcode 0x2B computes register minus r/m.
- R4: After a flag-updating operation, `sf_o` equals bit 31 of the result. `zf_o` is 1 exactly when the result is zero.
- R5: For add, `cf_o` is 1 when the unsigned sum does not fit in 32 bits. `of_o` is 1 when the signed sum does not fit in 32 bits. For example, 0x80000000+0x80000000 gives 0 with SF=0, ZF=1, CF=1 and OF=1.
- R6: For subtract, `cf_o` is 1 when the exact unsigned difference is negative, so 0 minus 1 sets carry. `of_o` is 1 when the exact signed difference does not fit in 32 bits.
- R7: AND, OR and XOR clear `cf_o` and `of_o`.
- R8: Compare updates the flags exactly as subtract does, in the same operand order. It never asserts `wr_en_o`. `result_o` shows the difference.
- R9: Opcode 0xF7 with subfield 2 outputs the bitwise inverse of the r/m operand and writes it to r/m. All four flags stay unchanged.
- R10: Flags change only on a rising edge while `valid_i` is high. A synchronous reset clears the flags and `illegal_o`.
- R11: Any other opcode, or 0xF7 with another subfield, is treated as illegal.
  - `wr_en_o` stays low.
  - The flags stay unchanged.
  - `illegal_o` is high for the one cycle after the edge that accepted the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | The operation on the inputs is to be executed |
| opcode_i | input | 8 | Opcode byte |
| subop_i | input | 3 | Subfield of the operand-format byte |
| reg_opnd_i | input | 32 | Register operand |
| rm_opnd_i | input | 32 | Register-or-memory operand |
| result_o | output | 32 | Computed value |
| wr_en_o | output | 1 | Write the result back |
| wr_to_rm_o | output | 1 | 1: destination is r/m; 0: destination is the register |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| illegal_o | output | 1 | Unknown encoding was accepted in the previous cycle |

## Verification
The bench builds the block with its default data width of 32 bits, so that the fixed sign-boundary values 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF are real corners of the arithmetic. Random operands are drawn partly from those boundary values. This makes carry and overflow appear alone, together and not at all, for both operand orders. Opcodes are drawn from all legal encodings plus near-miss illegal bytes and 0xF7 subfields, with the valid strobe sometimes low. This checks that the flags hold across NOT, compare, illegal and idle cycles.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        K_ADD  = 3'd0,
        K_SUB  = 3'd1,
        K_AND  = 3'd2,
        K_OR   = 3'd3,
        K_XOR  = 3'd4,
        K_CMP  = 3'd5,
        K_NOT  = 3'd6,
        K_NONE = 3'd7
    } alu_kind_e;

    typedef struct packed {
        logic sf;
        logic zf;
        logic cf;
        logic of;
    } alu_flags_t;

    typedef struct packed {
        alu_kind_e kind;
        logic      legal;
        logic      writes;
        logic      to_rm;
        logic      upd_flags;
        logic      reg_first;
    } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
#(
    parameter int OPC_W = 8,
    parameter int SUB_W = 3
) (
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [SUB_W-1:0] subop_i,
    output alu_ctrl_t        ctrl_o
);
    localparam logic [SUB_W-1:0] NOT_SUBOP = SUB_W'(2);

    always_comb begin
        ctrl_o           = '0;
        ctrl_o.kind      = K_NONE;
        ctrl_o.to_rm     = ~opcode_i[1];
        ctrl_o.reg_first = opcode_i[1];
        case (opcode_i)
            8'h01, 8'h03: ctrl_o.kind = K_ADD;
            8'h29, 8'h2B: ctrl_o.kind = K_SUB;
            8'h21, 8'h23: ctrl_o.kind = K_AND;
            8'h09, 8'h0B: ctrl_o.kind = K_OR;
            8'h31, 8'h33: ctrl_o.kind = K_XOR;
            8'h39, 8'h3B: ctrl_o.kind = K_CMP;
            8'hF7: begin
                if (subop_i == NOT_SUBOP) begin
                    ctrl_o.kind = K_NOT;
                end
                ctrl_o.to_rm = 1'b1;
            end
            default: ctrl_o.kind = K_NONE;
        endcase
        ctrl_o.legal     = (ctrl_o.kind != K_NONE);
        ctrl_o.writes    = ctrl_o.legal && (ctrl_o.kind != K_CMP);
        ctrl_o.upd_flags = ctrl_o.legal && (ctrl_o.kind != K_NOT);
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_ctrl_t         ctrl_i,
    input  logic [DATA_W-1:0] reg_opnd_i,
    input  logic [DATA_W-1:0] rm_opnd_i,
    output logic [DATA_W-1:0] result_o,
    output alu_flags_t        flags_o
);
    localparam int EXT_W = DATA_W + 1;

    logic [DATA_W-1:0] lhs, rhs;
    logic [EXT_W-1:0]  uns_sum, uns_dif;
    logic [EXT_W-1:0]  sgn_sum, sgn_dif;
    logic              arith_sub;

    // Operand order only matters for subtract and compare.
    always_comb begin
        lhs = ctrl_i.reg_first ? reg_opnd_i : rm_opnd_i;
        rhs = ctrl_i.reg_first ? rm_opnd_i  : reg_opnd_i;
    end

    // Exact-width results: zero-extended for carry, sign-extended for overflow.
    always_comb begin
        uns_sum = {1'b0, lhs} + {1'b0, rhs};
        uns_dif = {1'b0, lhs} - {1'b0, rhs};
        sgn_sum = {lhs[DATA_W-1], lhs} + {rhs[DATA_W-1], rhs};
        sgn_dif = {lhs[DATA_W-1], lhs} - {rhs[DATA_W-1], rhs};
    end

    always_comb begin
        arith_sub = (ctrl_i.kind == K_SUB) || (ctrl_i.kind == K_CMP);
        result_o  = '0;
        flags_o   = '0;
        case (ctrl_i.kind)
            K_ADD:        result_o = uns_sum[DATA_W-1:0];
            K_SUB, K_CMP: result_o = uns_dif[DATA_W-1:0];
            K_AND:        result_o = lhs & rhs;
            K_OR:         result_o = lhs | rhs;
            K_XOR:        result_o = lhs ^ rhs;
            K_NOT:        result_o = ~rm_opnd_i;
            default:      result_o = '0;
        endcase
        flags_o.sf = result_o[DATA_W-1];
        flags_o.zf = (result_o == '0);
        if (ctrl_i.kind == K_ADD) begin
            flags_o.cf = uns_sum[DATA_W];
            flags_o.of = sgn_sum[DATA_W] != sgn_sum[DATA_W-1];
        end else if (arith_sub) begin
            flags_o.cf = uns_dif[DATA_W];
            flags_o.of = sgn_dif[DATA_W] != sgn_dif[DATA_W-1];
        end
    end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OPC_W  = 8,
    parameter int SUB_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [SUB_W-1:0]  subop_i,
    input  logic [DATA_W-1:0] reg_opnd_i,
    input  logic [DATA_W-1:0] rm_opnd_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic              wr_to_rm_o,
    output logic              sf_o,
    output logic              zf_o,
    output logic              cf_o,
    output logic              of_o,
    output logic              illegal_o
);
    typedef struct packed {
        alu_flags_t flags;
        logic       illegal;
    } state_t;

    alu_ctrl_t  ctrl;
    alu_flags_t new_flags;
    state_t     st_d, st_q;

    alu_decode #(.OPC_W(OPC_W), .SUB_W(SUB_W)) u_dec (
        .opcode_i (opcode_i),
        .subop_i  (subop_i),
        .ctrl_o   (ctrl)
    );

    alu_core #(.DATA_W(DATA_W)) u_core (
        .ctrl_i     (ctrl),
        .reg_opnd_i (reg_opnd_i),
        .rm_opnd_i  (rm_opnd_i),
        .result_o   (result_o),
        .flags_o    (new_flags)
    );

    always_comb begin
        st_d         = st_q;
        st_d.illegal = valid_i && !ctrl.legal;
        if (valid_i && ctrl.upd_flags) begin
            st_d.flags = new_flags;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o    = valid_i && ctrl.writes;
    assign wr_to_rm_o = ctrl.to_rm;
    assign sf_o       = st_q.flags.sf;
    assign zf_o       = st_q.flags.zf;
    assign cf_o       = st_q.flags.cf;
    assign of_o       = st_q.flags.of;
    assign illegal_o  = st_q.illegal;

    // Requirement R4: zero flag tracks the previous flag-updating result
    assert_zero_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_i && ctrl.upd_flags) |=> (zf_o == ($past(result_o) == '0)));

    // Requirement R7: logic ops clear carry and overflow
    assert_logic_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (opcode_i[7:4] != 4'h3 || opcode_i[3:0] == 4'h1 || opcode_i[3:0] == 4'h3)
         && (opcode_i == 8'h21 || opcode_i == 8'h23 || opcode_i == 8'h09 ||
             opcode_i == 8'h0B || opcode_i == 8'h31 || opcode_i == 8'h33))
        |=> (!cf_o && !of_o));

    // Requirement R8: compare never writes back
    assert_cmp_no_write_R8: assert property (@(posedge clk) disable iff (rst)
        (opcode_i == 8'h39 || opcode_i == 8'h3B) |-> !wr_en_o);

    // Requirement R9: NOT keeps the flags
    assert_not_keeps_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (valid_i && ctrl.kind == K_NOT) |=> $stable({sf_o, zf_o, cf_o, of_o}));

    // Requirement R10: idle cycles keep the flags
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable({sf_o, zf_o, cf_o, of_o}) && !illegal_o));

    // Requirement R11: an illegal op pulses illegal_o and keeps the flags
    assert_illegal_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !ctrl.legal) |=> (illegal_o && $stable({sf_o, zf_o, cf_o, of_o})));

    // Requirement R11: nothing is written for an illegal op
    assert_illegal_no_write_R11: assert property (@(posedge clk) disable iff (rst)
        !ctrl.legal |-> !wr_en_o);
endmodule

// File: tb/sim_alu_flags_unit.sv
`timescale 1ns/1ps
module sim_alu_flags_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [7:0]  opcode_i;
    logic [2:0]  subop_i;
    logic [31:0] reg_opnd_i, rm_opnd_i;
    logic [31:0] result_o;
    logic        wr_en_o, wr_to_rm_o, sf_o, zf_o, cf_o, of_o, illegal_o;

    int tests = 0;
    int fails = 0;
    logic [3:0] mflags;

    always #2 clk = ~clk;

    alu_flags_unit u0 (
        .clk(clk), .rst(rst), .valid_i(valid_i), .opcode_i(opcode_i),
        .subop_i(subop_i), .reg_opnd_i(reg_opnd_i), .rm_opnd_i(rm_opnd_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .wr_to_rm_o(wr_to_rm_o),
        .sf_o(sf_o), .zf_o(zf_o), .cf_o(cf_o), .of_o(of_o), .illegal_o(illegal_o)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Reference model: 0 add,1 sub,2 and,3 or,4 xor,5 cmp,6 not,7 illegal
    function automatic int kind_of(input logic [7:0] o, input logic [2:0] s);
        case (o)
            8'h01, 8'h03: return 0;
            8'h29, 8'h2B: return 1;
            8'h21, 8'h23: return 2;
            8'h09, 8'h0B: return 3;
            8'h31, 8'h33: return 4;
            8'h39, 8'h3B: return 5;
            8'hF7:        return (s == 3'd2) ? 6 : 7;
            default:      return 7;
        endcase
    endfunction

    task automatic model(input logic [7:0] o, input logic [2:0] s,
                         input logic [31:0] r, input logic [31:0] m,
                         output int k, output logic [31:0] res, output logic [3:0] fl);
        longint a_s, b_s, ex_s;
        longint unsigned a_u, b_u, ex_u;
        logic [31:0] a, b;
        logic c, v;
        k = kind_of(o, s);
        a = o[1] ? r : m;
        b = o[1] ? m : r;
        a_s = longint'($signed(a)); b_s = longint'($signed(b));
        a_u = {32'd0, a};           b_u = {32'd0, b};
        c = 1'b0; v = 1'b0; res = 32'd0;
        case (k)
            0: begin ex_s = a_s + b_s; ex_u = a_u + b_u; res = a + b;
                     c = (ex_u != {32'd0, res}); v = (ex_s != longint'($signed(res))); end
            1, 5: begin ex_s = a_s - b_s; res = a - b;
                     c = (a_u < b_u); v = (ex_s != longint'($signed(res))); end
            2: res = a & b;
            3: res = a | b;
            4: res = a ^ b;
            6: res = ~m;
            default: res = 32'd0;
        endcase
        fl = {res[31], res == 32'd0, c, v};
    endtask

    task automatic run_op(input logic [7:0] o, input logic [2:0] s,
                          input logic [31:0] r, input logic [31:0] m, input logic v);
        int k;
        logic [31:0] er;
        logic [3:0] ef;
        logic ewr;
        @(negedge clk);
        valid_i = v; opcode_i = o; subop_i = s; reg_opnd_i = r; rm_opnd_i = m;
        model(o, s, r, m, k, er, ef);
        ewr = v && (k != 5) && (k != 7);
        #1;
        chk(wr_en_o == ewr, (k == 7) ? "R11 wr_en" : (k == 5) ? "R8 wr_en" : "R2 wr_en",
            32'(wr_en_o), 32'(ewr));
        if (v && k != 7) begin
            chk(result_o == er, (k == 1) ? "R3 result" : (k == 6) ? "R9 result" : "R1 result",
                result_o, er);
            if (ewr)
                chk(wr_to_rm_o == ((k == 6) ? 1'b1 : ~o[1]), "R2 destination",
                    32'(wr_to_rm_o), 32'((k == 6) ? 1'b1 : ~o[1]));
        end
        if (v && k < 6) mflags = ef;
        @(posedge clk);
        #1;
        chk({sf_o, zf_o, cf_o, of_o} == mflags,
            !v ? "R10 hold" : (k == 0) ? "R5 flags" : (k == 1) ? "R6 flags" :
            (k == 5) ? "R8 flags" : (k == 6) ? "R9 flags" : (k == 7) ? "R11 flags" : "R7 R4 flags",
            32'({sf_o, zf_o, cf_o, of_o}), 32'(mflags));
        chk(illegal_o == (v && k == 7), "R11 illegal pulse", 32'(illegal_o), 32'(v && k == 7));
        valid_i = 1'b0;
    endtask

    function automatic logic [31:0] pick_val();
        logic [31:0] c [5] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};
        if ($urandom_range(0, 2) == 0) return c[$urandom_range(0, 4)];
        return $urandom();
    endfunction

    initial begin
        #(4 * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] ops [16] = '{8'h01, 8'h03, 8'h29, 8'h2B, 8'h21, 8'h23, 8'h09, 8'h0B,
                                 8'h31, 8'h33, 8'h39, 8'h3B, 8'hF7, 8'h05, 8'h2A, 8'hFF};
        void'($urandom(32'd20240611));
        rst = 1'b1; valid_i = 1'b0; opcode_i = 8'h0; subop_i = 3'd0;
        reg_opnd_i = '0; rm_opnd_i = '0; mflags = 4'h0;
        repeat (3) @(posedge clk);
        #1;
        chk({sf_o, zf_o, cf_o, of_o, illegal_o} == 5'b0, "R10 reset",
            32'({sf_o, zf_o, cf_o, of_o, illegal_o}), 32'h0);
        rst = 1'b0;

        // Directed corners
        run_op(8'h01, 3'd0, 32'h80000000, 32'h80000000, 1'b1); // R5 CF+OF, ZF
        run_op(8'h03, 3'd0, 32'h7FFFFFFF, 32'h00000001, 1'b1); // R5 OF, SF
        run_op(8'h2B, 3'd0, 32'h00000000, 32'h00000001, 1'b1); // R6 borrow
        run_op(8'h2B, 3'd0, 32'h80000000, 32'h7FFFFFFF, 1'b1); // R6 OF
        run_op(8'h29, 3'd0, 32'h00000001, 32'h0000000A, 1'b1); // R3 rm-reg
        run_op(8'h21, 3'd0, 32'h000000FF, 32'h0A0B0C0D, 1'b1); // R7
        run_op(8'h3B, 3'd0, 32'h7FFFFFFF, 32'h80000000, 1'b1); // R8
        run_op(8'h39, 3'd0, 32'h0A0B0C07, 32'h0A0B0C0D, 1'b1); // R8 rm-reg
        run_op(8'hF7, 3'd2, 32'h0, 32'h0F0F00FF, 1'b1);       // R9
        run_op(8'hF7, 3'd3, 32'h0, 32'h0F0F00FF, 1'b1);       // R11 bad subfield
        run_op(8'h02, 3'd0, 32'h1, 32'h1, 1'b1);              // R11 bad opcode
        run_op(8'h01, 3'd0, 32'hFFFFFFFF, 32'h1, 1'b0);       // R10 idle

        for (int i = 0; i < 3000; i++) begin
            run_op(ops[$urandom_range(0, 15)], 3'($urandom_range(0, 7)),
                   pick_val(), pick_val(), $urandom_range(0, 7) != 0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule